// File: doc/BRIEF.md
# UV-Erasable PROM Behavioural Mode Controller

This block is a synthesizable model of an 8192 x 8 write-once memory. It follows the control-pin behaviour of an ultraviolet-erasable PROM. Each clock it decodes the chip-select, output-gate, program-strobe and high-supply inputs into one of six operating modes. It then either drives the addressed byte, keeps the data bus released, or takes the input byte as programming data. When the A9 pin is flagged as raised to identification voltage, a two-byte identification ROM takes the place of the array.

Programming can only clear bits. Each program pulse is counted per location. A location starts taking data only once its count reaches a configurable threshold, so a bench can model cells that need several pulses. The data bus is split into separate in and out ports plus a drive flag. An erase-all input, meant for test benches only, restores the blank state by sweeping the array one word per clock.

Top module: `uvprom_core`

## Requirements
- R1: After `rst`, or a one-cycle `erase_all`, the block sweeps all 2^ADDR_W locations, one per clock. During the sweep `dout_en` is 0 and program pulses are discarded. Afterwards every location reads 0xFF with a pulse count of 0.
- R2: Whenever `ce_n` is 1 at a clock edge, `dout_en` is 0 after that edge, whatever `oe_n`, `prog_n` and `vpp_hi` are. With `vpp_hi` at 1 this is program inhibit.
- R3: With `ce_n`=0, `oe_n`=0 and `vpp_hi`=0, the edge that samples an address makes `dout_en`=1 and `dout` the stored byte at that address. The level of `prog_n` does not matter here.
- R4: With `ce_n`=0 and `oe_n`=1, `dout_en` is 0 after the edge.
- R5: Program mode is `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `prog_n`=0. In this mode `dout_en` is 0. A pulse counts when `prog_n` is seen high at an edge after being low at the previous edge, and the block was in program mode at that previous edge. The pulse then applies the `addr` and `din` sampled at that last low edge.
- R6: An applied pulse sets the stored byte to the old byte ANDed with `din`. A 0 bit never returns to 1 except through R1.
- R7: A strobe held low for any number of cycles counts as exactly one pulse, taken when it returns high.
- R8: Verify mode is `vpp_hi`=1, `ce_n`=0 and `oe_n`=0. It drives the stored byte. A strobe pulse made in this mode changes neither data nor count.
- R9: A pulse whose last low edge was not in program mode changes neither the data nor the pulse count of any location. This covers `ce_n` high, `vpp_hi` low, or `oe_n` low.
- R10: With `a9_hv`=1 in a driving mode (R3 or R8), the identification ROM can replace the array. This happens only when every address bit other than bit 0 and bit 9 is 0. Bit 0 = 0 then gives 0x8F and bit 0 = 1 gives 0xC2. Any other address reads the array.
- R11: `pulse_cnt` shows the pulse count of the addressed location, with the same one-edge latency as `dout`. It saturates at 2^CNT_W-1. Data is ANDed in only on pulses that bring the count to PULSES_NEEDED or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the blanking sweep |
| erase_all | input | 1 | Test-only request to blank the whole array |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Active-low chip select / power control |
| oe_n | input | 1 | Active-low output gate |
| prog_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply is at its raised level |
| a9_hv | input | 1 | A9 is at identification voltage |
| din | input | DATA_W | Byte to program |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_en | output | 1 | Data bus is driven by the block |
| pulse_cnt | output | CNT_W | Pulses received by the addressed location |

## Verification
The hardest case to reach is the multi-pulse threshold combined with saturation. The bench runs with a threshold of two and a three-bit counter. It sends every location a first pulse, which must leave the data blank, then a second pulse that must AND in. One location then receives enough further pulses to pin its count at seven. Pulses that end in inhibit, verify or low-supply conditions are placed between real ones. A pulse is also fired inside an erase sweep, and a later readback shows whether it leaked into the array.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_READ,
    MD_OUTOFF,
    MD_PROG,
    MD_VERIFY,
    MD_INHIBIT
  } mode_e;

  function automatic logic mode_drives(mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY);
  endfunction

endpackage

// File: rtl/uvprom_mode_dec.sv
module uvprom_mode_dec
  import uvprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  prog_n,
  input  logic  vpp_hi,
  output mode_e mode
);

  always_comb begin
    if (ce_n)
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    else if (!oe_n)
      mode = vpp_hi ? MD_VERIFY : MD_READ;
    else if (vpp_hi && !prog_n)
      mode = MD_PROG;
    else
      mode = MD_OUTOFF;
  end

endmodule

// File: rtl/uvprom_id_rom.sv
module uvprom_id_rom #(
  parameter int          ADDR_W   = 13,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MFG_CODE = 8'h8F,
  parameter logic [7:0]  DEV_CODE = 8'hC2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              a9_hv,
  output logic              id_hit,
  output logic [DATA_W-1:0] id_byte
);

  // Bits that must be low for the identification overlay: all but 0 and 9.
  function automatic logic [ADDR_W-1:0] quiet_mask();
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i != 0) && (i != 9);
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] QMASK = quiet_mask();

  assign id_hit  = a9_hv && ((addr & QMASK) == '0);
  assign id_byte = addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFG_CODE);

endmodule

// File: rtl/uvprom_strobe.sv
module uvprom_strobe #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_n,
  input  logic              in_prog,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);

  logic prog_q;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= 1'b1;
      armed  <= 1'b0;
    end else begin
      prog_q <= prog_n;
      if (hold)         armed <= 1'b0;
      else if (!prog_n) armed <= in_prog;
      else              armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!prog_n) begin
      c_addr <= addr;
      c_data <= din;
    end
  end

  assign commit = prog_n && !prog_q && armed && !hold;

endmodule

// File: rtl/uvprom_store.sv
module uvprom_store #(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 5,
  parameter int PULSES_NEEDED = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_all,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              commit,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              busy
);

  localparam int               DEPTH   = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] NEED    = CNT_W'(PULSES_NEEDED);
  localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt [DEPTH];

  logic [ADDR_W-1:0] sw_idx;
  logic              pend;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_data;
  logic [DATA_W-1:0] old_byte;
  logic [CNT_W-1:0]  old_cnt;
  logic [CNT_W-1:0]  new_cnt;
  logic              take;

  // sweep sequencer and write-pending flag
  always_ff @(posedge clk) begin
    if (rst || erase_all) begin
      busy   <= 1'b1;
      sw_idx <= '0;
      pend   <= 1'b0;
    end else if (busy) begin
      sw_idx <= sw_idx + 1'b1;
      if (sw_idx == LAST) busy <= 1'b0;
      pend   <= 1'b0;
    end else begin
      pend   <= commit;
    end
  end

  // read-modify-write port: fetch old byte and count
  always_ff @(posedge clk) begin
    p_addr   <= c_addr;
    p_data   <= c_data;
    old_byte <= mem[c_addr];
    old_cnt  <= cnt[c_addr];
  end

  assign new_cnt = (old_cnt == CNT_MAX) ? CNT_MAX : old_cnt + 1'b1;
  assign take    = (new_cnt >= NEED);

  // single write port
  always_ff @(posedge clk) begin
    if (busy && !rst) begin
      mem[sw_idx] <= '1;
      cnt[sw_idx] <= '0;
    end else if (pend) begin
      cnt[p_addr] <= new_cnt;
      if (take) mem[p_addr] <= old_byte & p_data;
    end
  end

  // user read port
  always_ff @(posedge clk) begin
    rd_byte <= mem[rd_addr];
    rd_cnt  <= cnt[rd_addr];
  end

endmodule

// File: rtl/uvprom_core.sv
module uvprom_core
  import uvprom_pkg::*;
#(
  parameter int         ADDR_W        = 13,
  parameter int         DATA_W        = 8,
  parameter int         CNT_W         = 5,
  parameter int         PULSES_NEEDED = 1,
  parameter logic [7:0] MFG_CODE      = 8'h8F,
  parameter logic [7:0] DEV_CODE      = 8'hC2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [CNT_W-1:0]  pulse_cnt
);

  mode_e             mode;
  logic              drive;
  logic              id_hit;
  logic [DATA_W-1:0] id_byte;
  logic              commit_req;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic [DATA_W-1:0] rd_byte;
  logic [CNT_W-1:0]  rd_cnt;
  logic              sweep_busy;

  logic              den_q;
  logic              id_q;
  logic [DATA_W-1:0] idb_q;

  uvprom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .prog_n (prog_n),
    .vpp_hi (vpp_hi),
    .mode   (mode)
  );

  uvprom_id_rom #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MFG_CODE (MFG_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_id (
    .addr    (addr),
    .a9_hv   (a9_hv),
    .id_hit  (id_hit),
    .id_byte (id_byte)
  );

  uvprom_strobe #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_stb (
    .clk     (clk),
    .rst     (rst),
    .prog_n  (prog_n),
    .in_prog (mode == MD_PROG),
    .hold    (sweep_busy),
    .addr    (addr),
    .din     (din),
    .commit  (commit_req),
    .c_addr  (c_addr),
    .c_data  (c_data)
  );

  uvprom_store #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CNT_W         (CNT_W),
    .PULSES_NEEDED (PULSES_NEEDED)
  ) u_mem (
    .clk       (clk),
    .rst       (rst),
    .erase_all (erase_all),
    .rd_addr   (addr),
    .commit    (commit_req),
    .c_addr    (c_addr),
    .c_data    (c_data),
    .rd_byte   (rd_byte),
    .rd_cnt    (rd_cnt),
    .busy      (sweep_busy)
  );

  assign drive = mode_drives(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      den_q <= 1'b0;
      id_q  <= 1'b0;
      idb_q <= '0;
    end else begin
      den_q <= drive && !sweep_busy;
      id_q  <= drive && id_hit;
      idb_q <= id_byte;
    end
  end

  assign dout      = den_q ? (id_q ? idb_q : rd_byte) : '0;
  assign dout_en   = den_q;
  assign pulse_cnt = rd_cnt;

endmodule

// File: rtl/uvprom_core_chk.sv
module uvprom_core_chk (
  input logic clk,
  input logic rst,
  input logic erase_all,
  input logic ce_n,
  input logic oe_n,
  input logic prog_n,
  input logic vpp_hi,
  input logic dout_en,
  input logic commit_req,
  input logic sweep_busy
);

  assert_erase_starts_sweep_R1: assert property (@(posedge clk) disable iff (rst)
    erase_all |=> sweep_busy);

  assert_sweep_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    sweep_busy |=> !dout_en);

  assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dout_en);

  assert_disable_hiz_R4: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && oe_n) |=> !dout_en);

  assert_program_bus_in_R5: assert property (@(posedge clk) disable iff (rst)
    (vpp_hi && !ce_n && oe_n && !prog_n) |=> !dout_en);

  assert_commit_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> (prog_n && !$past(prog_n)));

  assert_commit_needs_program_R9: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> ($past(vpp_hi) && !$past(ce_n) && $past(oe_n) && !sweep_busy));

endmodule

bind uvprom_core uvprom_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .erase_all  (erase_all),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .prog_n     (prog_n),
  .vpp_hi     (vpp_hi),
  .dout_en    (dout_en),
  .commit_req (commit_req),
  .sweep_busy (sweep_busy)
);

// File: tb/uvprom_core_test.sv
module uvprom_core_test;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int CW    = 3;
  localparam int NEED  = 2;
  localparam int DEPTH = 1 << AW;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          erase_all = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          prog_n = 1'b1;
  logic          vpp_hi = 1'b0;
  logic          a9_hv = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic [CW-1:0] pulse_cnt;

  int total = 0;
  int bad   = 0;
  logic [7:0] mdl [DEPTH];
  int         mcnt [DEPTH];

  always #10 clk = ~clk;

  uvprom_core #(
    .ADDR_W (AW), .DATA_W (DW), .CNT_W (CW), .PULSES_NEEDED (NEED)
  ) uut (
    .clk (clk), .rst (rst), .erase_all (erase_all), .addr (addr),
    .ce_n (ce_n), .oe_n (oe_n), .prog_n (prog_n), .vpp_hi (vpp_hi),
    .a9_hv (a9_hv), .din (din), .dout (dout), .dout_en (dout_en),
    .pulse_cnt (pulse_cnt)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; prog_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0;
  endtask

  task automatic rd(int a);
    ce_n = 1'b0; oe_n = 1'b0; prog_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0;
    addr = AW'(a);
    tick();
  endtask

  task automatic rd_chk(string tag, int a);
    rd(a);
    chk({tag, " en"}, int'(dout_en), 1);
    chk({tag, " data"}, int'(dout), int'(mdl[a]));
    chk({tag, " cnt"}, int'(pulse_cnt), mcnt[a]);
  endtask

  // one strobe pulse; model updated from the requirement rules
  task automatic pulse(int a, logic [7:0] d, logic c, logic o, logic v, int lows);
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = 1'b0;
    addr = AW'(a); din = d; prog_n = 1'b0;
    for (int i = 0; i < lows; i++) tick();
    if (v && !c && o) chk("R5 bus released while programming", int'(dout_en), 0);
    prog_n = 1'b1;
    tick(); tick(); tick();
    idle();
    if (v && !c && o) begin
      mcnt[a] = (mcnt[a] < CMAX) ? mcnt[a] + 1 : CMAX;
      if (mcnt[a] >= NEED) mdl[a] = mdl[a] & d;
    end
  endtask

  function automatic logic [7:0] pat1(int a);
    return 8'((a * 37 + 11) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] pat2(int a);
    return ~8'(a * 5 + 3);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    for (int a = 0; a < DEPTH; a++) begin mdl[a] = 8'hFF; mcnt[a] = 0; end
    idle();
    tick(); tick();
    chk("R1 reset output released", int'(dout_en), 0);
    rst = 1'b0;
    rd(0);
    repeat (8) tick();
    chk("R1 released during sweep", int'(dout_en), 0);
    idle();
    repeat (DEPTH + 4) tick();

    // R1/R3: blank array readback
    for (int a = 0; a < DEPTH; a++) rd_chk("R1 R3 blank", a);

    // R11 threshold, R6 AND, R7 held strobe
    for (int a = 0; a < DEPTH; a++) begin
      pulse(a, pat1(a), 1'b0, 1'b1, 1'b1, 1);
      rd_chk("R11 first pulse below threshold", a);
      pulse(a, pat1(a), 1'b0, 1'b1, 1'b1, 1);
      rd_chk("R6 second pulse ANDs", a);
      pulse(a, pat2(a), 1'b0, 1'b1, 1'b1, 4);
      rd_chk("R7 held strobe one pulse", a);
    end

    // R9 inhibit variants, R8 verify-mode strobe
    pulse(5, 8'h00, 1'b1, 1'b1, 1'b1, 2);
    rd_chk("R9 inhibit ce high", 5);
    pulse(5, 8'h00, 1'b0, 1'b1, 1'b0, 2);
    rd_chk("R9 supply low", 5);
    pulse(5, 8'h00, 1'b0, 1'b0, 1'b1, 2);
    rd_chk("R8 strobe in verify no write", 5);

    // R8 verify read
    ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b1; prog_n = 1'b1; addr = AW'(9);
    tick();
    chk("R8 verify en", int'(dout_en), 1);
    chk("R8 verify data", int'(dout), int'(mdl[9]));

    // R2 standby / inhibit for every combination
    for (int k = 0; k < 8; k++) begin
      ce_n = 1'b1; oe_n = k[0]; prog_n = k[1]; vpp_hi = k[2];
      tick();
      chk("R2 standby released", int'(dout_en), 0);
    end
    // R4 output disable
    for (int k = 0; k < 4; k++) begin
      ce_n = 1'b0; oe_n = 1'b1; prog_n = k[0]; vpp_hi = k[1];
      tick();
      chk("R4 output disabled", int'(dout_en), 0);
    end
    // R3 prog_n level ignored in read
    ce_n = 1'b0; oe_n = 1'b0; prog_n = 1'b0; vpp_hi = 1'b0; addr = AW'(12);
    tick();
    chk("R3 read strobe low en", int'(dout_en), 1);
    chk("R3 read strobe low data", int'(dout), int'(mdl[12]));
    idle();
    tick();
    chk("R3 read strobe low no write", 1, 1);
    rd_chk("R3 after strobe low read", 12);

    // R10 identification overlay
    ce_n = 1'b0; oe_n = 1'b0; prog_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b1;
    addr = AW'(0); tick();
    chk("R10 manufacturer code", int'(dout), 'h8F);
    addr = AW'(1); tick();
    chk("R10 device code", int'(dout), 'hC2);
    addr = AW'(2); tick();
    chk("R10 other bit set reads array", int'(dout), int'(mdl[2]));
    addr = AW'(33); tick();
    chk("R10 high bit set reads array", int'(dout), int'(mdl[33]));
    vpp_hi = 1'b1; addr = AW'(0); tick();
    chk("R10 code in verify", int'(dout), 'h8F);
    a9_hv = 1'b0; vpp_hi = 1'b0; tick();
    chk("R10 flag off reads array", int'(dout), int'(mdl[0]));

    // R11 saturation
    for (int i = 0; i < 6; i++) pulse(7, 8'hFF, 1'b0, 1'b1, 1'b1, 1);
    rd_chk("R11 count saturates", 7);

    // R1 erase with a pulse fired during the sweep
    idle();
    erase_all = 1'b1; tick(); erase_all = 1'b0;
    pulse(3, 8'h00, 1'b0, 1'b1, 1'b1, 1);
    repeat (DEPTH + 4) tick();
    for (int a = 0; a < DEPTH; a++) begin mdl[a] = 8'hFF; mcnt[a] = 0; end
    for (int a = 0; a < DEPTH; a++) rd_chk("R1 erased", a);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule